// File: doc/BRIEF.md
# Reference-Clock Seconds and Cycle Counters

This block keeps time from a fixed reference clock. The default reference is 25,000,000 Hz. It exposes two 32-bit read-only registers through a single-cycle register port. The first register counts whole seconds since the last reset. The second counts reference cycles within the current second, but only in coarse steps: every 16 reference cycles (640 ns at the default rate) it adds 16. Its low four bits therefore always read zero.

The block runs on a system clock. A `ref_tick` input marks each system-clock cycle that stands for one reference-clock period. An internal divide-by-16 prescaler counts these ticks and produces the update strobe for the cycle register.

When an update would make the cycle register reach the reference frequency, the register returns to zero instead. In that same cycle the seconds register increments. Writes on the port are accepted but change nothing.

Top module: `ref_sec_counter`

## Requirements
- R1: While `rst_n` is low, and right after it rises, both the seconds register and the cycle register read zero.
- R2: The cycle register, read at `reg_addr` = 1, increases by exactly 16 once for every 16 cycles with `ref_tick` high. After N ticks since reset it reads 16·floor(N/16) mod REF_HZ.
- R3: Bits [3:0] of the cycle register always read zero.
- R4: The cycle register never reaches REF_HZ. The update that follows the value REF_HZ−16 gives zero.
- R5: The seconds register, read at `reg_addr` = 0, increments by one in exactly the cycle where the cycle register wraps to zero. At no other time does it change, so after N ticks it reads floor(N/REF_HZ).
- R6: Cycles with `ref_tick` low change neither register.
- R7: A write (`reg_wr` high) to either register, with any `reg_wdata`, leaves both registers unchanged. This holds even in the cycle where a wrap happens.
- R8: Reads of any address other than 0 or 1 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | High for one system cycle per reference-clock period |
| reg_addr | input | AW (2) | Register select: 0 seconds, 1 cycles |
| reg_wr | input | 1 | Write strobe (ignored) |
| reg_wdata | input | DW (32) | Write data (ignored) |
| reg_rdata | output | DW (32) | Combinational read data for `reg_addr` |

## Verification
Two events can fall in the same cycle: the cycle register wrapping, which also advances the seconds register, and a port write aimed at either register. The bench drives the tick count to one tick short of a full second. It then issues an all-ones write to the cycle register, and later to the seconds register, on the exact tick that causes the wrap. After that edge it expects the cycle register at zero and the seconds register one higher. The wrap edge is also reached many times under random tick gaps, random writes and random reads. Every read is compared with values computed from a tick count the bench keeps itself.

// File: rtl/ref_sec_counter.sv
module ref_sec_counter #(
  parameter int REF_HZ = 25_000_000,
  parameter int SHIFT  = 4,
  parameter int DW     = 32,
  parameter int AW     = 2,
  parameter logic [AW-1:0] SEC_ADDR = 0,
  parameter logic [AW-1:0] CYC_ADDR = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_tick,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata
);
  localparam int QW = DW - SHIFT;
  localparam logic [QW-1:0] LAST_Q = QW'((REF_HZ >> SHIFT) - 1);

  logic [SHIFT-1:0] pre;
  logic [QW-1:0]    cyc_q;
  logic [DW-1:0]    sec_q;

  wire upd  = ref_tick && (&pre);
  wire wrap = upd && (cyc_q == LAST_Q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre   <= '0;
      cyc_q <= '0;
      sec_q <= '0;
    end else begin
      if (ref_tick) pre <= pre + 1'b1;
      if (upd) cyc_q <= wrap ? '0 : cyc_q + 1'b1;
      if (wrap) sec_q <= sec_q + 1'b1;
    end
  end

  wire [DW-1:0] cyc_val = {cyc_q, {SHIFT{1'b0}}};

  assign reg_rdata = (reg_addr == SEC_ADDR) ? sec_q :
                     (reg_addr == CYC_ADDR) ? cyc_val : '0;

  logic unused_wr;
  assign unused_wr = ^{reg_wr, reg_wdata};
endmodule

// File: rtl/ref_sec_counter_chk.sv
module ref_sec_counter_chk #(
  parameter int REF_HZ = 25_000_000,
  parameter int SHIFT  = 4,
  parameter int DW     = 32,
  parameter int AW     = 2,
  parameter logic [AW-1:0] CYC_ADDR = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_tick,
  input logic [SHIFT-1:0] pre,
  input logic [DW-1:0]    cyc,
  input logic [DW-1:0]    sec,
  input logic [AW-1:0]    reg_addr,
  input logic [DW-1:0]    reg_rdata
);
  localparam logic [DW-1:0] STEP = DW'(2 ** SHIFT);
  localparam logic [DW-1:0] LAST = DW'(REF_HZ) - STEP;

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != $past(cyc)) |-> (cyc == $past(cyc) + STEP || cyc == '0));

  p_low_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == CYC_ADDR) |-> (reg_rdata[SHIFT-1:0] == '0));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cyc <= LAST);

  p_wrap_sec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_tick && (&pre) && cyc == LAST) |=> (cyc == '0 && sec == $past(sec) + 1'b1));

  p_sec_only_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sec != $past(sec)) |-> (cyc == '0));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_tick |=> ($stable(cyc) && $stable(sec)));
endmodule

bind ref_sec_counter ref_sec_counter_chk #(
  .REF_HZ(REF_HZ), .SHIFT(SHIFT), .DW(DW), .AW(AW), .CYC_ADDR(CYC_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .pre(pre),
  .cyc(cyc_val), .sec(sec_q), .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/tb_ref_sec_counter.sv
`timescale 1ns/1ps
module tb_ref_sec_counter;
  localparam int HZ = 320;
  localparam int SH = 4;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        ref_tick = 0;
  logic [1:0]  reg_addr = 0;
  logic        reg_wr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  longint ticks = 0;

  ref_sec_counter #(.REF_HZ(HZ), .SHIFT(SH)) dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) ticks <= 0;
    else if (ref_tick) ticks <= ticks + 1;
  end

  function automatic logic [31:0] exp_read(logic [1:0] a);
    if (a == 2'd0) return 32'(ticks / HZ);
    if (a == 2'd1) return 32'((((ticks >> SH) << SH)) % HZ);
    return 32'd0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic read_chk(logic [1:0] a, string req);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp_read(a));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int seed_unused;
    logic [31:0] sec_before;
    seed_unused = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    read_chk(2'd0, "R1 seconds in reset");
    read_chk(2'd1, "R1 cycles in reset");
    rst_n = 1;
    @(negedge clk);
    read_chk(2'd0, "R1 seconds after reset");
    read_chk(2'd1, "R1 cycles after reset");

    // R6: no ticks, no change
    repeat (40) @(negedge clk);
    read_chk(2'd1, "R6 cycles idle");
    read_chk(2'd0, "R6 seconds idle");

    // R2: first step after 16 ticks
    ref_tick = 1;
    repeat (15) @(negedge clk);
    reg_addr = 2'd1; #1;
    check("R2 before first step", reg_rdata, 32'd0);
    @(negedge clk);
    reg_addr = 2'd1; #1;
    check("R2 first step", reg_rdata, 32'd16);
    ref_tick = 0;

    // R7: writes with no ticks
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      reg_addr = 2'(i % 2); reg_wr = 1; reg_wdata = $urandom;
      @(negedge clk);
      reg_wr = 0;
      read_chk(2'd0, "R7 seconds after write");
      read_chk(2'd1, "R7 cycles after write");
    end

    // R8
    read_chk(2'd2, "R8 unmapped 2");
    read_chk(2'd3, "R8 unmapped 3");

    // R4/R5/R7: wrap coinciding with writes
    for (int k = 0; k < 2; k++) begin
      ref_tick = 1;
      while ((ticks % HZ) != HZ - 1) @(negedge clk);
      reg_addr = 2'd1; #1;
      check("R4 last value before wrap", reg_rdata, 32'(HZ - 16));
      reg_addr = 2'd0; #1;
      sec_before = reg_rdata;
      reg_addr = 2'(1 - k); reg_wr = 1; reg_wdata = 32'hFFFF_FFFF;
      @(negedge clk);
      reg_wr = 0; ref_tick = 0;
      reg_addr = 2'd1; #1;
      check("R4 wrap to zero with write", reg_rdata, 32'd0);
      reg_addr = 2'd0; #1;
      check("R5 seconds step on wrap with write", reg_rdata, sec_before + 32'd1);
    end

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      reg_addr = 2'($urandom % 4);
      #1;
      if (reg_addr == 2'd0) check("R5 seconds random", reg_rdata, exp_read(2'd0));
      else if (reg_addr == 2'd1) begin
        check("R2 cycles random", reg_rdata, exp_read(2'd1));
        check("R3 low bits zero", {28'd0, reg_rdata[3:0]}, 32'd0);
      end else check("R8 unmapped random", reg_rdata, 32'd0);
      ref_tick  = ($urandom % 4) != 0;
      reg_wr    = ($urandom % 3) == 0;
      reg_wdata = $urandom;
    end
    @(negedge clk);
    ref_tick = 0; reg_wr = 0;
    @(negedge clk);
    read_chk(2'd0, "R5 final seconds");
    read_chk(2'd1, "R2 final cycles");
    finish_run();
  end
endmodule